// File: doc/BRIEF.md
# Configuration Access Router

This block sits in front of a root port's configuration path. It takes a configuration request made of a target bus, device, function and register offset. It decides where the access is sent. Bus 0 is the root port itself, so the access goes straight to the local configuration aperture. Any other bus goes through a remote window that lies at a fixed distance above the local aperture. Before that access, a setup register is loaded with a routing word that says which bus, device and function is the target. The routing word also says whether a Type 0 or a Type 1 request is sent.

Bus 1 is the root port's logical secondary bus, so it is reached with Type 0 requests. Buses 2 and above lie behind further bridges and need Type 1 requests. The register offset is always rounded down to a 32-bit boundary. Device or function values that do not fit their fields are rejected. A rejected request issues no access and leaves the setup register unchanged.

The results appear one clock after the request is presented. The setup register changes on the same edge that issues a remote access.

Top module: `cfg_route_sel`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is 0 (acc_valid, acc_err, acc_remote, acc_type1, acc_addr, setup_word, setup_wr, setup_wr_ofs).
- R2: A valid request to bus 0 gives acc_valid=1, acc_remote=0, acc_type1=0 and acc_addr = LOCAL_BASE + aligned offset one cycle later. It leaves setup_word unchanged and does not raise setup_wr.
- R3: A valid request to bus 1 gives acc_remote=1, acc_type1=0 and acc_addr = LOCAL_BASE + REMOTE_OFS (0x1000) + aligned offset. setup_word becomes {7'b0, type bit 24 = 0, bus in bits 23:16, 3'b0, device in bits 12:8, 5'b0, function in bits 2:0}.
- R4: A valid request to a bus of 2 or more gives acc_remote=1 and acc_type1=1, with the same remote address as R3. In the setup word, bit 24 is set and the other fields are laid out as in R3.
- R5: The offset used in acc_addr is the request offset with its two low bits cleared.
- R6: setup_word is loaded on the same edge that raises acc_valid for a remote access. On that edge setup_wr pulses for one cycle, and setup_wr_ofs shows the setup register's application offset 0x008 (it is 0 otherwise). setup_word then holds its value until the next accepted remote request.
- R7: A request whose device value exceeds 31, or whose function value exceeds 7, gives acc_err=1 and acc_valid=0 one cycle later. setup_word, setup_wr and acc_addr stay as if there were no request.
- R8: Every output is registered and responds exactly one cycle after req_valid. In a cycle after one with no request, acc_valid, acc_err, acc_remote, acc_type1, setup_wr and acc_addr are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_bus | input | 8 | Target bus number |
| req_dev | input | DEV_IN_W (8) | Target device number, legal 0..31 |
| req_fn | input | FN_IN_W (8) | Target function number, legal 0..7 |
| req_ofs | input | OFS_W (12) | Register byte offset within the function |
| acc_valid | output | 1 | Accepted access issued |
| acc_err | output | 1 | Request rejected, field out of range |
| acc_remote | output | 1 | Access goes through the remote window |
| acc_type1 | output | 1 | Remote access is Type 1 |
| acc_addr | output | ADDR_W (32) | Aperture address of the access |
| setup_word | output | 32 | Contents of the setup register |
| setup_wr | output | 1 | Setup register was loaded this cycle |
| setup_wr_ofs | output | 12 | Application offset of the setup register while setup_wr is high |

## Verification
The routing decision is tried on the three bus classes: bus 0, bus 1, and buses 2 and 255. This tells the local path apart from Type 0 remote routing and from Type 1 remote routing. Offsets with nonzero low bits, and the top offset 0xFFF, show that alignment and window addition are separate steps. Requests at the field limits (device 31, function 7) and just past them (device 32, function 8, device 255) show where acceptance ends and rejection begins. Sequences that interleave a remote request, then a bus-0 request or a rejected request, then idle cycles, then another remote request, show that the setup register changes only on accepted remote requests.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int SETUP_W   = 32;
    localparam int BUS_LSB   = 16;
    localparam int DEV_LSB   = 8;
    localparam int TYPE1_BIT = 24;

    typedef enum logic [1:0] {
        ROUTE_LOCAL = 2'd0,
        ROUTE_TYPE0 = 2'd1,
        ROUTE_TYPE1 = 2'd2
    } route_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
    } target_t;

    function automatic route_e pick_route(input logic [BUS_W-1:0] bus);
        if (bus == '0)
            return ROUTE_LOCAL;
        else if (bus == BUS_W'(1))
            return ROUTE_TYPE0;
        else
            return ROUTE_TYPE1;
    endfunction

    function automatic logic [SETUP_W-1:0] pack_setup(input target_t t, input logic type1);
        logic [SETUP_W-1:0] w;
        w = '0;
        w[BUS_LSB +: BUS_W] = t.bus;
        w[DEV_LSB +: DEV_W] = t.dev;
        w[0 +: FN_W]        = t.fn;
        w[TYPE1_BIT]        = type1;
        return w;
    endfunction

endpackage

// File: rtl/cfg_route_classify.sv
module cfg_route_classify
    import cfg_route_pkg::*;
#(
    parameter int DEV_IN_W = 8,
    parameter int FN_IN_W  = 8
) (
    input  logic                req_valid,
    input  logic [BUS_W-1:0]    req_bus,
    input  logic [DEV_IN_W-1:0] req_dev,
    input  logic [FN_IN_W-1:0]  req_fn,
    output route_e              route,
    output target_t             target,
    output logic                accept,
    output logic                reject
);
    logic dev_over;
    logic fn_over;

    generate
        if (DEV_IN_W > DEV_W) begin : g_dev_chk
            assign dev_over = |req_dev[DEV_IN_W-1:DEV_W];
        end else begin : g_dev_fit
            assign dev_over = 1'b0;
        end
        if (FN_IN_W > FN_W) begin : g_fn_chk
            assign fn_over = |req_fn[FN_IN_W-1:FN_W];
        end else begin : g_fn_fit
            assign fn_over = 1'b0;
        end
    endgenerate

    always_comb begin
        route      = pick_route(req_bus);
        target.bus = req_bus;
        target.dev = req_dev[DEV_W-1:0];
        target.fn  = req_fn[FN_W-1:0];
        reject     = req_valid && (dev_over || fn_over);
        accept     = req_valid && !(dev_over || fn_over);
    end
endmodule

// File: rtl/cfg_route_addr.sv
module cfg_route_addr
    import cfg_route_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                OFS_W      = 12,
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] REMOTE_OFS = 32'h0000_1000
) (
    input  route_e             route,
    input  logic [OFS_W-1:0]   ofs,
    output logic [ADDR_W-1:0]  addr
);
    localparam logic [ADDR_W-1:0] REMOTE_BASE = LOCAL_BASE + REMOTE_OFS;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ofs_al;

    always_comb begin
        base   = (route == ROUTE_LOCAL) ? LOCAL_BASE : REMOTE_BASE;
        ofs_al = ADDR_W'({ofs[OFS_W-1:2], 2'b00});
        addr   = base + ofs_al;
    end
endmodule

// File: rtl/cfg_route_setup.sv
module cfg_route_setup
    import cfg_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [SETUP_W-1:0] word_in,
    output logic [SETUP_W-1:0] word_q,
    output logic               loaded
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            loaded <= 1'b0;
        end else begin
            loaded <= load;
            if (load)
                word_q <= word_in;
        end
    end
endmodule

// File: rtl/cfg_route_sel.sv
module cfg_route_sel
    import cfg_route_pkg::*;
#(
    parameter int                DEV_IN_W   = 8,
    parameter int                FN_IN_W    = 8,
    parameter int                OFS_W      = 12,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] REMOTE_OFS = 32'h0000_1000,
    parameter logic [11:0]       SETUP_OFS  = 12'h008
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [7:0]          req_bus,
    input  logic [DEV_IN_W-1:0] req_dev,
    input  logic [FN_IN_W-1:0]  req_fn,
    input  logic [OFS_W-1:0]    req_ofs,
    output logic                acc_valid,
    output logic                acc_err,
    output logic                acc_remote,
    output logic                acc_type1,
    output logic [ADDR_W-1:0]   acc_addr,
    output logic [31:0]         setup_word,
    output logic                setup_wr,
    output logic [11:0]         setup_wr_ofs
);
    route_e             route;
    target_t            target;
    logic               accept;
    logic               reject;
    logic [ADDR_W-1:0]  addr_nxt;
    logic               is_remote;
    logic               is_type1;
    logic               load;
    logic [SETUP_W-1:0] word_nxt;

    cfg_route_classify #(.DEV_IN_W(DEV_IN_W), .FN_IN_W(FN_IN_W)) u_classify (
        .req_valid (req_valid),
        .req_bus   (req_bus),
        .req_dev   (req_dev),
        .req_fn    (req_fn),
        .route     (route),
        .target    (target),
        .accept    (accept),
        .reject    (reject)
    );

    cfg_route_addr #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W),
        .LOCAL_BASE(LOCAL_BASE), .REMOTE_OFS(REMOTE_OFS)
    ) u_addr (
        .route (route),
        .ofs   (req_ofs),
        .addr  (addr_nxt)
    );

    always_comb begin
        is_remote = (route != ROUTE_LOCAL);
        is_type1  = (route == ROUTE_TYPE1);
        load      = accept && is_remote;
        word_nxt  = pack_setup(target, is_type1);
    end

    cfg_route_setup u_setup (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .word_in (word_nxt),
        .word_q  (setup_word),
        .loaded  (setup_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid  <= 1'b0;
            acc_err    <= 1'b0;
            acc_remote <= 1'b0;
            acc_type1  <= 1'b0;
            acc_addr   <= '0;
        end else begin
            acc_valid  <= accept;
            acc_err    <= reject;
            acc_remote <= accept && is_remote;
            acc_type1  <= accept && is_type1;
            acc_addr   <= accept ? addr_nxt : '0;
        end
    end

    assign setup_wr_ofs = setup_wr ? SETUP_OFS : 12'h000;
endmodule

// File: rtl/cfg_route_sel_chk.sv
module cfg_route_sel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_err,
    input logic              acc_remote,
    input logic              acc_type1,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       setup_word,
    input logic              setup_wr
);
    AST_LOCAL_KEEPS_SETUP: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_remote) |-> ($stable(setup_word) && !setup_wr)); // R2
    AST_TYPE_MATCHES_WORD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_remote) |-> (setup_word[24] == acc_type1)); // R4
    AST_TYPE1_IS_REMOTE: assert property (@(posedge clk) disable iff (rst)
        acc_type1 |-> (acc_remote && acc_valid)); // R3
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_addr[1:0] == 2'b00)); // R5
    AST_WR_WITH_REMOTE: assert property (@(posedge clk) disable iff (rst)
        setup_wr |-> (acc_valid && acc_remote)); // R6
    AST_HOLD_WITHOUT_WR: assert property (@(posedge clk) disable iff (rst)
        !setup_wr |-> $stable(setup_word)); // R6
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> (!acc_valid && !setup_wr && acc_addr == '0)); // R7
endmodule

bind cfg_route_sel cfg_route_sel_chk #(.ADDR_W(ADDR_W)) u_cfg_route_sel_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_err    (acc_err),
    .acc_remote (acc_remote),
    .acc_type1  (acc_type1),
    .acc_addr   (acc_addr),
    .setup_word (setup_word),
    .setup_wr   (setup_wr)
);

// File: tb/test_cfg_route_sel.sv
module test_cfg_route_sel;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] LBASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_dev = '0;
    logic [7:0]  req_fn = '0;
    logic [11:0] req_ofs = '0;
    logic        acc_valid, acc_err, acc_remote, acc_type1, setup_wr;
    logic [31:0] acc_addr, setup_word;
    logic [11:0] setup_wr_ofs;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    logic [31:0] m_setup = '0;
    logic        e_valid, e_err, e_remote, e_type1, e_wr;
    logic [31:0] e_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_route_sel i_cfg_route_sel (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bus(req_bus),
        .req_dev(req_dev), .req_fn(req_fn), .req_ofs(req_ofs),
        .acc_valid(acc_valid), .acc_err(acc_err), .acc_remote(acc_remote),
        .acc_type1(acc_type1), .acc_addr(acc_addr), .setup_word(setup_word),
        .setup_wr(setup_wr), .setup_wr_ofs(setup_wr_ofs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk({req, " valid"},  32'(acc_valid),  32'(e_valid));
        chk({req, " err"},    32'(acc_err),    32'(e_err));
        chk({req, " remote"}, 32'(acc_remote), 32'(e_remote));
        chk({req, " type1"},  32'(acc_type1),  32'(e_type1));
        chk({req, " addr"},   acc_addr,        e_addr);
        chk({req, " setup"},  setup_word,      m_setup);
        chk({req, " wr"},     32'(setup_wr),   32'(e_wr));
        chk({req, " wr_ofs"}, 32'(setup_wr_ofs), e_wr ? 32'h8 : 32'h0);
    endtask

    // drive one cycle (called at a negedge), model it, compare at the next negedge
    task automatic step(input string req, input logic v, input int bus,
                        input int dev, input int fn, input int ofs);
        int al;
        req_valid = v;
        req_bus = 8'(bus); req_dev = 8'(dev); req_fn = 8'(fn); req_ofs = 12'(ofs);
        al = ofs - (ofs % 4);
        e_valid = 0; e_err = 0; e_remote = 0; e_type1 = 0; e_wr = 0; e_addr = 0;
        if (v && (dev > 31 || fn > 7)) begin
            e_err = 1;
        end else if (v) begin
            e_valid = 1;
            if (bus == 0) begin
                e_addr = LBASE + 32'(al);
            end else begin
                e_remote = 1;
                e_type1 = (bus > 1);
                e_wr = 1;
                e_addr = LBASE + 32'h1000 + 32'(al);
                m_setup = (bus * 65536) + (dev * 256) + fn + (bus > 1 ? 32'h0100_0000 : 0);
            end
        end
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        e_valid = 0; e_err = 0; e_remote = 0; e_type1 = 0; e_wr = 0; e_addr = 0;
        // R1: reset state, with a request present during reset
        req_valid = 1; req_bus = 8'd3;
        repeat (3) @(negedge clk);
        compare_all("R1 in reset");
        req_valid = 0;
        rst = 0;
        @(negedge clk);
        compare_all("R1 after reset");

        step("R2 bus0 ofs0",        1, 0, 0, 0, 12'h000);
        step("R2 R5 bus0 ofs 0x13", 1, 0, 2, 1, 12'h013);
        step("R8 idle",             0, 0, 0, 0, 0);
        step("R3 bus1 dev3 fn2",    1, 1, 3, 2, 12'h044);
        step("R2 bus0 keeps setup", 1, 0, 31, 7, 12'h0FE);
        step("R8 idle keeps setup", 0, 0, 0, 0, 0);
        step("R4 bus2",             1, 2, 5, 1, 12'h101);
        step("R4 R5 bus255 max",    1, 255, 31, 7, 12'hFFF);
        step("R7 dev32 rejected",   1, 4, 32, 0, 12'h010);
        step("R7 fn8 rejected",     1, 1, 0, 8, 12'h010);
        step("R7 dev255 bus0",      1, 0, 255, 0, 12'h010);
        step("R3 bus1 back-to-back",1, 1, 0, 0, 12'h003);
        step("R6 bus1 second",      1, 1, 31, 7, 12'h800);
        step("R4 R6 bus 0x80",      1, 128, 16, 4, 12'h7FD);
        step("R8 idle tail",        0, 0, 0, 0, 0);
        step("R6 hold tail",        0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule